// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block is the host-facing front end of a display controller. A host reaches it over one of three transfer styles. Two are 8-bit parallel buses: one uses an enable strobe with a read/write level, and the other uses separate active-low read and write strobes. The third is a serial stream that can only write. Two static configuration pins pick the style. A pair of chip-select pins, one active low and one active high, gate every transfer.

All host pins are brought into the system clock domain through two-flop synchronizers, and strobe edges are detected in that domain. Each completed write produces a one-cycle `wr_valid` pulse with the byte and a data/command flag. Each parallel read produces a one-cycle `rd_req` pulse with its own flag. The upstream logic answers a read on `rd_data`. The block puts that byte on `db_out` and raises `db_oe` while a selected parallel read is in progress. Decoding of commands, the frame memory and status generation are all outside this block.

Top module: `hostbus_frontend`

## Requirements
- R1: The block counts as selected only while `sel_n` is 0 and `sel` is 1. While deselected, strobe and RS activity produce no `wr_valid` or `rd_req` pulse, and `db_oe` stays 0.
- R2: In enable-strobe mode (`bus6800`=1), a write happens when `e_rd` falls while `rw_wr` is 0. `wr_byte` then equals the bus value present before the fall.
- R3: In enable-strobe mode, `e_rd` rising while `rw_wr` is 1 starts a read and gives one `rd_req` pulse. `db_oe` is 1 and `db_out` equals `rd_data` while `e_rd` and `rw_wr` are both held at 1.
- R4: In split-strobe mode (`bus6800`=0), `rw_wr` acts as an active-low write strobe, and its rising edge completes a write of the bus byte.
- R5: In split-strobe mode, `e_rd` acts as an active-low read strobe. Its falling edge gives one `rd_req` pulse, and `db_oe` is 1 while it stays low.
- R6: `wr_is_data` and `rd_is_data` take the value of `rs_in` for that transfer (1 = display data, 0 = command or status). This holds in every mode.
- R7: In serial mode (`par_mode`=0), `db_in[7]` is the data and `db_in[6]` is the clock. Bits are taken on the rising clock edges, MSB first, and the eighth edge emits the byte.
- R8: Deselecting in serial mode clears the shift register and the bit counter, so a partial byte is thrown away. The next byte starts again from bit 7.
- R9: Serial mode never raises `db_oe` and never issues `rd_req`, even when read strobes are applied.
- R10: Each completed transfer produces exactly one pulse, and each pulse is one cycle long.
- R11: While `rst` is 1 and right after it, `wr_valid`, `rd_req` and `db_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | 1 = parallel bus, 0 = serial (static) |
| bus6800 | input | 1 | 1 = enable/RW style, 0 = split read/write strobes (static) |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| rs_in | input | 1 | 1 = display data, 0 = command/status |
| e_rd | input | 1 | Enable strobe or active-low read strobe |
| rw_wr | input | 1 | Read/write level or active-low write strobe |
| db_in | input | 8 | Data bus input pins; bits 7 and 6 are serial data and clock |
| rd_data | input | 8 | Read byte supplied by upstream logic |
| db_out | output | 8 | Data bus output value |
| db_oe | output | 1 | Data bus output enable |
| wr_valid | output | 1 | One-cycle write pulse |
| wr_is_data | output | 1 | Data/command flag of the write |
| wr_byte | output | 8 | Written byte |
| rd_req | output | 1 | One-cycle read request pulse |
| rd_is_data | output | 1 | Data/status flag of the current read |

## Verification
The assertions assume that `par_mode` and `bus6800` change only while the block is deselected. They also assume that every host strobe level and every serial clock level lasts at least two system clock cycles, so that no two detected edges of one strobe fall in adjacent cycles. The stimulus holds each pin state for three to five cycles. Mode changes happen only while the chip select is off, and idle strobe levels are then given time to settle before reselecting. A reference queue of expected writes and reads is compared against the pulses on every clock.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int HBI_DW = 8;
    localparam int HBI_BITCNT_W = $clog2(HBI_DW);

    typedef enum logic {
        FLAV_SPLIT  = 1'b0,
        FLAV_ENABLE = 1'b1
    } bus_flavour_e;

    typedef struct packed {
        logic              valid;
        logic              is_data;
        logic [HBI_DW-1:0] dat;
    } xfer_t;

    function automatic logic went_high(input logic was, input logic now);
        return !was && now;
    endfunction

    function automatic logic went_low(input logic was, input logic now);
        return was && !now;
    endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_par_engine.sv
module hbi_par_engine
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  bus_flavour_e      flav,
    input  logic              sel_now,
    input  logic              rs_now,
    input  logic              rs_was,
    input  logic              a_now,
    input  logic              a_was,
    input  logic              b_now,
    input  logic              b_was,
    input  logic [HBI_DW-1:0] bus_was,
    output xfer_t             wr,
    output logic              rd_req,
    output logic              rd_is_data,
    output logic              rd_active
);
    logic live;
    logic wr_ev, rd_ev, act;

    assign live = en && sel_now;

    always_comb begin
        if (flav == FLAV_ENABLE) begin
            // a = enable strobe, b = read/write level
            wr_ev = went_low(a_was, a_now) && !b_was;
            rd_ev = went_high(a_was, a_now) && b_now;
            act   = a_now && b_now;
        end else begin
            // a = active-low read, b = active-low write
            wr_ev = went_high(b_was, b_now);
            rd_ev = went_low(a_was, a_now);
            act   = !a_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr         <= '0;
            rd_req     <= 1'b0;
            rd_is_data <= 1'b0;
            rd_active  <= 1'b0;
        end else begin
            wr.valid  <= live && wr_ev;
            rd_req    <= live && rd_ev;
            rd_active <= live && act;
            if (live && wr_ev) begin
                wr.dat     <= bus_was;
                wr.is_data <= rs_was;
            end
            if (live && rd_ev) begin
                rd_is_data <= rs_now;
            end
        end
    end
endmodule

// File: rtl/hbi_ser_engine.sv
module hbi_ser_engine
    import hbi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  sel_now,
    input  logic  rs_was,
    input  logic  sclk_now,
    input  logic  sclk_was,
    input  logic  sd_was,
    output xfer_t wr
);
    logic [HBI_DW-1:0]       shreg;
    logic [HBI_BITCNT_W-1:0] cnt;
    logic                    done;
    logic                    flag;

    localparam logic [HBI_BITCNT_W-1:0] LAST = HBI_BITCNT_W'(HBI_DW - 1);

    always_ff @(posedge clk) begin
        if (rst || !(en && sel_now)) begin
            shreg <= '0;
            cnt   <= '0;
            done  <= 1'b0;
            flag  <= 1'b0;
        end else if (went_high(sclk_was, sclk_now)) begin
            shreg <= {shreg[HBI_DW-2:0], sd_was};
            cnt   <= cnt + 1'b1;
            done  <= (cnt == LAST);
            if (cnt == LAST) begin
                flag <= rs_was;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign wr.valid   = done;
    assign wr.is_data = flag;
    assign wr.dat     = shreg;
endmodule

// File: rtl/hostbus_frontend.sv
module hostbus_frontend
    import hbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_mode,
    input  logic              bus6800,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              rs_in,
    input  logic              e_rd,
    input  logic              rw_wr,
    input  logic [HBI_DW-1:0] db_in,
    input  logic [HBI_DW-1:0] rd_data,
    output logic [HBI_DW-1:0] db_out,
    output logic              db_oe,
    output logic              wr_valid,
    output logic              wr_is_data,
    output logic [HBI_DW-1:0] wr_byte,
    output logic              rd_req,
    output logic              rd_is_data
);
    localparam int CTL_W = 5;
    localparam int SCLK_BIT = HBI_DW - 2;
    localparam int SDAT_BIT = HBI_DW - 1;

    logic              cs_raw;
    logic [CTL_W-1:0]  ctl_now;
    logic [CTL_W-2:0]  ctl_was;
    logic [HBI_DW-1:0] bus_now, bus_was;
    xfer_t             par_wr, ser_wr, sel_wr;
    logic              par_rd_active;

    assign cs_raw = !sel_n && sel;

    hbi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .d   ({cs_raw, rs_in, e_rd, rw_wr, db_in[SCLK_BIT]}),
        .q   (ctl_now)
    );

    hbi_sync #(.W(HBI_DW), .STAGES(SYNC_STAGES)) u_sync_bus (
        .clk (clk),
        .rst (rst),
        .d   (db_in),
        .q   (bus_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_was <= '0;
            bus_was <= '0;
        end else begin
            ctl_was <= ctl_now[CTL_W-2:0];
            bus_was <= bus_now;
        end
    end

    hbi_par_engine u_par (
        .clk        (clk),
        .rst        (rst),
        .en         (par_mode),
        .flav       (bus6800 ? FLAV_ENABLE : FLAV_SPLIT),
        .sel_now    (ctl_now[4]),
        .rs_now     (ctl_now[3]),
        .rs_was     (ctl_was[3]),
        .a_now      (ctl_now[2]),
        .a_was      (ctl_was[2]),
        .b_now      (ctl_now[1]),
        .b_was      (ctl_was[1]),
        .bus_was    (bus_was),
        .wr         (par_wr),
        .rd_req     (rd_req),
        .rd_is_data (rd_is_data),
        .rd_active  (par_rd_active)
    );

    hbi_ser_engine u_ser (
        .clk      (clk),
        .rst      (rst),
        .en       (!par_mode),
        .sel_now  (ctl_now[4]),
        .rs_was   (ctl_was[3]),
        .sclk_now (ctl_now[0]),
        .sclk_was (ctl_was[0]),
        .sd_was   (bus_was[SDAT_BIT]),
        .wr       (ser_wr)
    );

    assign sel_wr     = par_mode ? par_wr : ser_wr;
    assign wr_valid   = sel_wr.valid;
    assign wr_is_data = sel_wr.is_data;
    assign wr_byte    = sel_wr.dat;

    // raw select gates the driver so deselect releases the bus at once
    assign db_oe  = cs_raw && par_mode && par_rd_active;
    assign db_out = db_oe ? rd_data : '0;
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker (
    input logic clk,
    input logic rst,
    input logic par_mode,
    input logic sel_n,
    input logic sel,
    input logic wr_valid,
    input logic rd_req,
    input logic db_oe
);
    a_r1_no_drive_deselected: assert property (@(posedge clk) disable iff (rst)
        !(!sel_n && sel) |-> !db_oe);

    a_r9_serial_never_drives: assert property (@(posedge clk) disable iff (rst)
        !par_mode |-> !db_oe);

    a_r9_serial_no_read_req: assert property (@(posedge clk) disable iff (rst)
        !par_mode |-> !rd_req);

    a_r10_write_single_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    a_r10_read_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    a_r11_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!wr_valid && !rd_req));
endmodule

bind hostbus_frontend hbi_checker u_hbi_checker (
    .clk      (clk),
    .rst      (rst),
    .par_mode (par_mode),
    .sel_n    (sel_n),
    .sel      (sel),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .db_oe    (db_oe)
);

// File: tb/hostbus_frontend_test.sv
module hostbus_frontend_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_mode = 1'b1, bus6800 = 1'b1;
    logic       sel_n = 1'b1, sel = 1'b0;
    logic       rs_in = 1'b0, e_rd = 1'b0, rw_wr = 1'b1;
    logic [7:0] db_in = 8'h00;
    logic [7:0] rd_data, db_out, wr_byte;
    logic       db_oe, wr_valid, wr_is_data, rd_req, rd_is_data;

    int checks = 0;
    int fails  = 0;
    logic [8:0] wr_q[$];
    logic       rd_q[$];
    string      cur_req = "R11";

    always #5 clk = ~clk;

    assign rd_data = rd_is_data ? 8'h3C : 8'hA5;

    hostbus_frontend uut (
        .clk(clk), .rst(rst), .par_mode(par_mode), .bus6800(bus6800),
        .sel_n(sel_n), .sel(sel), .rs_in(rs_in), .e_rd(e_rd), .rw_wr(rw_wr),
        .db_in(db_in), .rd_data(rd_data), .db_out(db_out), .db_oe(db_oe),
        .wr_valid(wr_valid), .wr_is_data(wr_is_data), .wr_byte(wr_byte),
        .rd_req(rd_req), .rd_is_data(rd_is_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model: every clock, compare pulses against queued expectations (R10)
    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            if (wr_q.size() == 0) chk({cur_req, " unexpected write"}, {23'd0, wr_is_data, wr_byte}, 32'h1FF);
            else chk({cur_req, " write R6 flag/byte"}, {23'd0, wr_is_data, wr_byte}, {23'd0, wr_q.pop_front()});
        end
        if (!rst && rd_req) begin
            if (rd_q.size() == 0) chk({cur_req, " unexpected read R9"}, 32'd1, 32'd0);
            else chk({cur_req, " read R6 flag"}, {31'd0, rd_is_data}, {31'd0, rd_q.pop_front()});
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select_on;  sel_n = 1'b0; sel = 1'b1; hold(4); endtask
    task automatic select_off; sel_n = 1'b1; sel = 1'b0; hold(4); endtask

    task automatic set_mode(input logic par, input logic m68);
        select_off();
        par_mode = par; bus6800 = m68;
        e_rd = m68 ? 1'b0 : 1'b1;
        rw_wr = 1'b1; db_in = 8'h00;
        hold(5);
    endtask

    task automatic en_write(input logic rs, input logic [7:0] b, input logic expect_it);
        rs_in = rs; rw_wr = 1'b0; db_in = b; hold(4);
        e_rd = 1'b1; hold(4);
        if (expect_it) wr_q.push_back({rs, b});
        e_rd = 1'b0; hold(4);
        rw_wr = 1'b1; hold(4);
    endtask

    task automatic en_read(input string req, input logic rs, input logic expect_it);
        rs_in = rs; rw_wr = 1'b1; hold(4);
        if (expect_it) rd_q.push_back(rs);
        e_rd = 1'b1; hold(5);
        chk({req, " oe during read"}, {31'd0, db_oe}, {31'd0, expect_it});
        chk({req, " db_out during read"}, {24'd0, db_out}, expect_it ? (rs ? 32'h3C : 32'hA5) : 32'h0);
        e_rd = 1'b0; hold(5);
        chk({req, " oe after read"}, {31'd0, db_oe}, 32'd0);
    endtask

    task automatic sp_write(input logic rs, input logic [7:0] b);
        rs_in = rs; db_in = b; hold(3);
        rw_wr = 1'b0; hold(4);
        wr_q.push_back({rs, b});
        rw_wr = 1'b1; hold(4);
    endtask

    task automatic sp_read(input string req, input logic rs);
        rs_in = rs; hold(3);
        rd_q.push_back(rs);
        e_rd = 1'b0; hold(5);
        chk({req, " oe during read"}, {31'd0, db_oe}, 32'd1);
        chk({req, " db_out during read"}, {24'd0, db_out}, rs ? 32'h3C : 32'hA5);
        e_rd = 1'b1; hold(5);
        chk({req, " oe after read"}, {31'd0, db_oe}, 32'd0);
    endtask

    task automatic ser_bits(input logic rs, input logic [7:0] b, input int n);
        rs_in = rs;
        for (int i = 7; i > 7 - n; i--) begin
            db_in[7] = b[i]; db_in[6] = 1'b0; hold(3);
            db_in[6] = 1'b1; hold(3);
        end
        db_in[6] = 1'b0; hold(3);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        hold(3);
        cur_req = "R11";
        chk("R11 wr_valid in reset", {31'd0, wr_valid}, 32'd0);
        chk("R11 rd_req in reset", {31'd0, rd_req}, 32'd0);
        chk("R11 db_oe in reset", {31'd0, db_oe}, 32'd0);
        rst = 1'b0;
        hold(4);
        chk("R11 wr_valid after reset", {31'd0, wr_valid}, 32'd0);

        // enable-strobe flavour
        cur_req = "R2";
        set_mode(1'b1, 1'b1);
        select_on();
        en_write(1'b1, 8'h5A, 1'b1);
        en_write(1'b0, 8'hC3, 1'b1);
        cur_req = "R3";
        en_read("R3", 1'b1, 1'b1);
        en_read("R3", 1'b0, 1'b1);

        // deselected activity is ignored (R1)
        cur_req = "R1";
        sel_n = 1'b1; sel = 1'b0; hold(4);
        en_write(1'b1, 8'h77, 1'b0);
        en_read("R1", 1'b1, 1'b0);
        sel_n = 1'b0; sel = 1'b0; hold(4);
        en_write(1'b0, 8'h11, 1'b0);
        en_read("R1", 1'b0, 1'b0);
        chk("R1 no pending write", wr_q.size(), 32'd0);

        // split-strobe flavour
        cur_req = "R4";
        set_mode(1'b1, 1'b0);
        select_on();
        sp_write(1'b1, 8'h81);
        sp_write(1'b0, 8'h00);
        sp_write(1'b1, 8'hFF);
        cur_req = "R5";
        sp_read("R5", 1'b0);
        sp_read("R5", 1'b1);

        // serial path
        cur_req = "R7";
        set_mode(1'b0, 1'b0);
        select_on();
        wr_q.push_back({1'b1, 8'hB4});
        ser_bits(1'b1, 8'hB4, 8);
        wr_q.push_back({1'b0, 8'h2D});
        ser_bits(1'b0, 8'h2D, 8);
        chk("R7 bytes delivered", wr_q.size(), 32'd0);

        // partial byte cleared by deselect (R8)
        cur_req = "R8";
        ser_bits(1'b1, 8'hE0, 3);
        select_off();
        select_on();
        wr_q.push_back({1'b1, 8'h96});
        ser_bits(1'b1, 8'h96, 8);
        chk("R8 partial byte dropped", wr_q.size(), 32'd0);

        // read strobes in serial mode (R9)
        cur_req = "R9";
        rw_wr = 1'b1;
        e_rd = 1'b0; hold(5);
        chk("R9 oe with read strobe low", {31'd0, db_oe}, 32'd0);
        e_rd = 1'b1; hold(5);
        e_rd = 1'b0; hold(5);
        chk("R9 oe serial", {31'd0, db_oe}, 32'd0);
        e_rd = 1'b1; hold(5);

        cur_req = "R10";
        select_off();
        hold(10);
        chk("R10 all writes seen once", wr_q.size(), 32'd0);
        chk("R10 all reads seen once", rd_q.size(), 32'd0);
        finish_run();
    end
endmodule